// File: doc/BRIEF.md
# Host Bridge Configuration Space with Upper-Memory Shadow Routing

This block holds the 256-byte configuration space of a host bridge. A simple register port carries a function number, a byte address, write data and a write strobe. Reads are combinational, so the byte addressed in a cycle is on the read bus in that same cycle. Identity bytes are fixed. Some bits of the high status byte can only be cleared, by writing a 1 to them. Every other byte is plain storage that loads a fixed value at reset.

Three of the storage bytes are shadow controls for the upper memory area, from C0000h to FFFFFh. Each one packs 2-bit fields, and each field picks where CPU reads and CPU writes go for one segment: internal DRAM or the external bus. The segments are 16 KB each from C0000h to DFFFFh, and 64 KB each at E0000h and F0000h.

A lookup port takes a 20-bit memory address and returns, in the same cycle, whether a read and a write to it are served internally. A status output reports when the system BIOS segment is read from DRAM. A synchronous soft-reset input returns the BIOS segment to external routing and leaves the rest of the configuration alone.

Top module: `hb_cfg_space`

## Requirements
- R1: After the asynchronous reset, bytes read as follows: 00h=06h, 01h=11h, 02h=85h, 03h=05h, 04h=07h, 06h=A0h, 07h=02h, 0Bh=06h, 58h=40h, 59h=05h, 5Ah..5Fh=01h, 64h=ABh. Every other byte reads 00h.
- R2: A write to byte 00h, 01h, 02h, 03h, 08h, 09h, 0Ah, 0Bh, 0Eh or 0Fh leaves that byte unchanged.
- R3: A write to byte 07h clears each stored bit at positions 7, 5 and 4 where the write data has a 1. No other bit of 07h changes, and no bit of 07h is ever set by a write.
- R4: Every byte not named in R2 or R3 stores the written value on the clock edge of the write. A read in the next cycle returns that value.
- R5: When the function number is not 0, reads return FFh and writes change nothing.
- R6: Each shadow field is 2 bits wide. Bit 1 set means reads go to internal DRAM. Bit 0 set means writes go to internal DRAM. The values are therefore 0 = both external, 1 = write internal only, 2 = read internal only, 3 = both internal.
- R7: Byte 61h bits [1:0], [3:2], [5:4] and [7:6] route the 16 KB segments at C0000h, C4000h, C8000h and CC000h, in that order.
- R8: Byte 62h bits [1:0], [3:2], [5:4] and [7:6] route the 16 KB segments at D0000h, D4000h, D8000h and DC000h, in that order.
- R9: Byte 63h bits [7:6] route the 64 KB segment at E0000h, and bits [5:4] route the 64 KB segment at F0000h.
- R10: Lookup addresses below C0000h report both read and write as internal.
- R11: `bios_shadowed` is high exactly when bit 5 of byte 63h is set, which is the read-internal bit of the F0000h field.
- R12: A cycle with `soft_rst` high clears bits 5:4 of byte 63h on that edge and keeps its other bits. This takes precedence over a write to 63h in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of the BIOS segment routing |
| cfg_fn | input | FN_W | Function number of the access |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Read data for `cfg_fn`/`cfg_addr` (combinational) |
| mem_addr | input | 20 | Memory address to look up |
| mem_rd_int | output | 1 | Reads at `mem_addr` are served by internal DRAM |
| mem_wr_int | output | 1 | Writes at `mem_addr` go to internal DRAM |
| bios_shadowed | output | 1 | F0000h segment is read from internal DRAM |

## Verification
Register writes and soft resets land on the clock edge where they are presented. The read bus and the lookup outputs are combinational, so a write is visible on the falling edge of the following cycle. The lookup and read outputs for unchanged inputs are visible on the falling edge of the same cycle. The bench's reference model applies each write at the rising edge, the same edge the design uses. All outputs are compared against the model at every falling edge. A check is therefore always made half a cycle after the last register update, and never sees inputs that are changing.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

  localparam int CFG_BYTES  = 256;
  localparam int CFG_AW     = 8;
  localparam int MEM_AW     = 20;

  localparam logic [7:0] STAT_HI_ADDR = 8'h07;
  localparam logic [7:0] STAT_CLR_MSK = 8'hB0;
  localparam logic [7:0] SHAD_C_ADDR  = 8'h61;
  localparam logic [7:0] SHAD_D_ADDR  = 8'h62;
  localparam logic [7:0] SHAD_EF_ADDR = 8'h63;
  localparam logic [7:0] SOFT_CLR_MSK = 8'h30;

  typedef enum logic [1:0] {
    BK_RW  = 2'd0,
    BK_RO  = 2'd1,
    BK_W1C = 2'd2
  } byte_kind_e;

  // route bits: [1] read internal, [0] write internal
  typedef logic [1:0] route_t;

  function automatic byte_kind_e kind_of(input int a);
    case (a)
      'h00, 'h01, 'h02, 'h03,
      'h08, 'h09, 'h0A, 'h0B,
      'h0E, 'h0F:             return BK_RO;
      int'(STAT_HI_ADDR):     return BK_W1C;
      default:                return BK_RW;
    endcase
  endfunction

  function automatic logic [7:0] reset_value(input int a);
    case (a)
      'h00: return 8'h06;
      'h01: return 8'h11;
      'h02: return 8'h85;
      'h03: return 8'h05;
      'h04: return 8'h07;
      'h06: return 8'hA0;
      'h07: return 8'h02;
      'h0B: return 8'h06;
      'h58: return 8'h40;
      'h59: return 8'h05;
      'h5A, 'h5B, 'h5C, 'h5D, 'h5E, 'h5F: return 8'h01;
      'h64: return 8'hAB;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] soft_mask(input int a);
    return (a == int'(SHAD_EF_ADDR)) ? SOFT_CLR_MSK : 8'h00;
  endfunction

  // pick a 2-bit field out of a packed shadow byte
  function automatic route_t field_of(input logic [7:0] r, input logic [1:0] slot);
    logic [7:0] s;
    s = r >> {slot, 1'b0};
    return s[1:0];
  endfunction

  function automatic route_t seg_route(input logic [MEM_AW-1:0] a,
                                       input logic [7:0] c_reg,
                                       input logic [7:0] d_reg,
                                       input logic [7:0] ef_reg);
    if (a[19:18] != 2'b11) return 2'b11;
    case (a[17:16])
      2'b00:   return field_of(c_reg, a[15:14]);
      2'b01:   return field_of(d_reg, a[15:14]);
      2'b10:   return ef_reg[7:6];
      default: return ef_reg[5:4];
    endcase
  endfunction

endpackage

// File: rtl/hb_cfg_regs.sv
module hb_cfg_regs
  import hb_cfg_pkg::*;
#(
  parameter int FN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [FN_W-1:0]   fn,
  input  logic [CFG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata,
  output logic [7:0]        shad_c,
  output logic [7:0]        shad_d,
  output logic [7:0]        shad_ef
);

  logic [7:0] byte_bus [CFG_BYTES];

  // named access events
  logic fn_zero, wr_ok, wr_hit_ro, wr_hit_w1c, wr_hit_rw;
  assign fn_zero    = (fn == '0);
  assign wr_ok      = we && fn_zero;
  assign wr_hit_ro  = wr_ok && (kind_of(int'(addr)) == BK_RO);
  assign wr_hit_w1c = wr_ok && (kind_of(int'(addr)) == BK_W1C);
  assign wr_hit_rw  = wr_ok && (kind_of(int'(addr)) == BK_RW);

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    localparam byte_kind_e KIND = kind_of(i);
    localparam logic [7:0] RST  = reset_value(i);
    localparam logic [7:0] SMSK = soft_mask(i);
    logic hit;
    assign hit = wr_ok && (addr == CFG_AW'(i));

    if (KIND == BK_RO) begin : g_ro
      assign byte_bus[i] = RST;
    end else if (KIND == BK_W1C) begin : g_w1c
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= RST;
        else if (hit) q <= q & ~(wdata & STAT_CLR_MSK);
      end
      assign byte_bus[i] = q;
    end else begin : g_rw
      logic [7:0] q;
      logic [7:0] q_nxt;
      always_comb begin
        q_nxt = hit ? wdata : q;
        if (soft_rst) q_nxt = q_nxt & ~SMSK;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= q_nxt;
      end
      assign byte_bus[i] = q;
    end
  end

  assign rdata   = fn_zero ? byte_bus[addr] : 8'hFF;
  assign shad_c  = byte_bus[SHAD_C_ADDR];
  assign shad_d  = byte_bus[SHAD_D_ADDR];
  assign shad_ef = byte_bus[SHAD_EF_ADDR];

  // R3
  stat_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((byte_bus[STAT_HI_ADDR] & ~$past(byte_bus[STAT_HI_ADDR])) == 8'h00));

  // R4
  rw_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_rw && !soft_rst) |=> (byte_bus[$past(addr)] == $past(wdata)));

  // R12
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (shad_ef[5:4] == 2'b00));

  // R5
  fn_other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fn_zero |-> (rdata == 8'hFF));

endmodule

// File: rtl/hb_shadow_route.sv
module hb_shadow_route
  import hb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        shad_c,
  input  logic [7:0]        shad_d,
  input  logic [7:0]        shad_ef,
  output logic              rd_int,
  output logic              wr_int
);

  route_t route;
  logic   in_upper;

  assign in_upper = (mem_addr[19:18] == 2'b11);
  assign route    = seg_route(mem_addr, shad_c, shad_d, shad_ef);
  assign rd_int   = route[1];
  assign wr_int   = route[0];

  // R10
  low_mem_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_upper |-> (rd_int && wr_int));

endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
  import hb_cfg_pkg::*;
#(
  parameter int FN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [FN_W-1:0]   cfg_fn,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              cfg_we,
  output logic [7:0]        cfg_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd_int,
  output logic              mem_wr_int,
  output logic              bios_shadowed
);

  logic [7:0] shad_c, shad_d, shad_ef;

  hb_cfg_regs #(.FN_W(FN_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .fn      (cfg_fn),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .we      (cfg_we),
    .rdata   (cfg_rdata),
    .shad_c  (shad_c),
    .shad_d  (shad_d),
    .shad_ef (shad_ef)
  );

  hb_shadow_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_addr(mem_addr),
    .shad_c  (shad_c),
    .shad_d  (shad_d),
    .shad_ef (shad_ef),
    .rd_int  (mem_rd_int),
    .wr_int  (mem_wr_int)
  );

  assign bios_shadowed = shad_ef[5];

  // R11
  bios_matches_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[19:16] == 4'hF) |-> (mem_rd_int == bios_shadowed));

endmodule

// File: tb/hb_cfg_space_test.sv
module hb_cfg_space_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [2:0]  cfg_fn = '0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [19:0] mem_addr = '0;
  logic        mem_rd_int, mem_wr_int, bios_shadowed;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;
  string phase = "";

  logic [7:0] m [256];

  always #10 clk = ~clk;

  hb_cfg_space uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_fn(cfg_fn), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
    .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_rd_int(mem_rd_int), .mem_wr_int(mem_wr_int), .bios_shadowed(bios_shadowed)
  );

  function automatic bit is_fixed(int a);
    return (a <= 3) || (a >= 8 && a <= 11) || a == 14 || a == 15;
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) m[a] = 8'h00;
    m[0] = 8'h06; m[1] = 8'h11; m[2] = 8'h85; m[3] = 8'h05;
    m[4] = 8'h07; m[6] = 8'hA0; m[7] = 8'h02; m[11] = 8'h06;
    m['h58] = 8'h40; m['h59] = 8'h05;
    for (int a = 'h5A; a <= 'h5F; a++) m[a] = 8'h01;
    m['h64] = 8'hAB;
  endtask

  // reference model, updated on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (cfg_we && cfg_fn == 0) begin
        int a;
        a = int'(cfg_addr);
        if (a == 7) begin
          for (int b = 0; b < 8; b++)
            if ((b == 7 || b == 5 || b == 4) && cfg_wdata[b]) m[7][b] = 1'b0;
        end else if (!is_fixed(a)) m[a] = cfg_wdata;
      end
      if (soft_rst) begin
        m['h63][5] = 1'b0;
        m['h63][4] = 1'b0;
      end
    end
  end

  function automatic int exp_field(int addr);
    int seg;
    if (addr < 'hC0000) return 3;
    if (addr >= 'hF0000) return (m['h63] >> 4) & 3;
    if (addr >= 'hE0000) return (m['h63] >> 6) & 3;
    seg = (addr - 'hC0000) / 'h4000;
    return (m['h61 + seg / 4] >> (2 * (seg % 4))) & 3;
  endfunction

  function automatic string rd_tag();
    if (phase != "") return phase;
    if (cfg_fn != 0) return "R5";
    if (is_fixed(int'(cfg_addr))) return "R2";
    if (cfg_addr == 8'h07) return "R3";
    return "R4";
  endfunction

  function automatic string mem_tag(int addr);
    if (addr < 'hC0000) return "R10";
    if (addr < 'hD0000) return "R6 R7";
    if (addr < 'hE0000) return "R6 R8";
    return "R6 R9";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      int f;
      f = exp_field(int'(mem_addr));
      check(rd_tag(), "cfg_rdata", int'(cfg_rdata),
            (cfg_fn != 0) ? 'hFF : int'(m[cfg_addr]));
      check(mem_tag(int'(mem_addr)), "mem_rd_int", int'(mem_rd_int), (f >> 1) & 1);
      check(mem_tag(int'(mem_addr)), "mem_wr_int", int'(mem_wr_int), f & 1);
      check("R11", "bios_shadowed", int'(bios_shadowed), int'(m['h63][5]));
    end
  end

  task automatic step(bit we, int fn, int a, int d, int ma);
    @(posedge clk); #2;
    cfg_we = we; cfg_fn = 3'(fn); cfg_addr = 8'(a); cfg_wdata = 8'(d); mem_addr = 20'(ma);
  endtask

  task automatic probe_all();
    for (int s = 0; s < 8; s++) begin
      step(0, 0, 'h61 + s / 4, 0, 'hC0000 + s * 'h4000);
      step(0, 0, 'h61, 0, 'hC0000 + s * 'h4000 + 'h3FFF);
    end
    step(0, 0, 'h63, 0, 'hE0000);
    step(0, 0, 'h63, 0, 'hEFFFF);
    step(0, 0, 'h63, 0, 'hF0000);
    step(0, 0, 'h63, 0, 'hFFFFF);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    live = 1;
    // R1: reset contents
    phase = "R1";
    for (int a = 0; a < 256; a++) step(0, 0, a, 0, a * 'h1357);
    phase = "";
    // R2 R3 R4: write all ones then zeros everywhere, read back
    for (int a = 0; a < 256; a++) begin step(1, 0, a, 'hFF, 'h12345); step(0, 0, a, 0, 'hBFFFF); end
    for (int a = 0; a < 256; a++) begin step(1, 0, a, 'h00, 'h00000); step(0, 0, a, 0, 'hC0000); end
    for (int a = 0; a < 256; a++) begin step(1, 0, a, a ^ 'h5A, 'hD4000); step(0, 0, a, 0, 'hF8000); end
    // R5: other functions
    for (int f = 1; f < 8; f++) begin
      step(1, f, 'h40 + f, 'hC3, 'hE1234);
      step(0, f, 'h40 + f, 0, 'hE1234);
      step(0, 0, 'h40 + f, 0, 'h0F000);
    end
    // R6 R7 R8 R9: sweep every encoding on every segment
    for (int v = 0; v < 4; v++) begin
      step(1, 0, 'h61, v * 'h55, 0);
      step(1, 0, 'h62, v * 'h55, 0);
      step(1, 0, 'h63, v * 'h55, 0);
      probe_all();
    end
    step(1, 0, 'h61, 'hE4, 0);
    step(1, 0, 'h62, 'h1B, 0);
    step(1, 0, 'h63, 'h9C, 0);
    probe_all();
    // R12: soft reset keeps other bits
    step(1, 0, 'h63, 'hFF, 'hF0000);
    phase = "R12";
    @(posedge clk); #2; cfg_we = 0; soft_rst = 1;
    step(0, 0, 'h63, 0, 'hF4000); soft_rst = 0;
    step(0, 0, 'h63, 0, 'hE4000);
    // R12: soft reset wins over a simultaneous write
    step(1, 0, 'h63, 'h7B, 'hF0000); soft_rst = 1;
    step(0, 0, 'h63, 0, 'hF0000); soft_rst = 0;
    step(0, 0, 'h63, 0, 'hFFFF0);
    phase = "";
    step(0, 0, 0, 0, 0);
    @(posedge clk); #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule